// File: doc/BRIEF.md
# Composite Video Sync Sequencer

This block produces the composite sync waveform for a progressive 312-line frame with PAL-style timing. It runs from one 24 MHz clock. A frame is a fixed sequence of 17 steps. The vertical interval is built from half-line pulses, each 32 µs long. Broad pulses are mostly low. Equalising pulses are mostly high. One step in the middle of the sequence holds the whole visible picture: a run of full-length video lines, each with a horizontal sync tip and a back porch. The sync output is low at the sync tip and high at the blanking level.

Alongside the sync level, the block drives three more outputs. The first is a strobe that marks the visible part of each picture line. The second is the index of the current picture line. The third is a single-cycle pulse at the very start of each frame, for triggering an oscilloscope. A downstream pixel serialiser uses the strobe and the line index to fetch and shift out pixels. All outputs are registered. All segment lengths are given as parameters in clock cycles.

Top module: `cvs_sync_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it is raised, `sync_o` is 1 and `active_o`, `frame_o` and `line_o` are 0. Each output shows the sequencer state of the previous cycle. The first cycle after reset release therefore shows the first cycle of a frame.
- R2: One frame is 17 steps in this order: steps 0 to 4 are broad half-lines, steps 5 to 9 are equalising half-lines, step 10 is the picture, and steps 11 to 16 are equalising half-lines. The step after 16 is step 0 of the next frame.
- R3: A broad half-line is HALF_LINE (768) cycles long. It is low for BROAD_LOW (720) cycles and then high for the remaining 48 cycles.
- R4: An equalising half-line is HALF_LINE (768) cycles long. It is low for EQUAL_LOW (48) cycles and then high for the remaining 720 cycles.
- R5: The picture step holds ACTIVE_LINES (default 304) lines. Each line is LINE_LEN (1536) cycles long.
- R6: Each picture line is low for HSYNC_LEN (113) cycles, then high for PORCH_LEN (137) cycles with `active_o` at 0. It then stays high, with `active_o` at 1, from cycle 250 of the line through the last cycle of the line. `active_o` is 0 outside picture lines.
- R7: During the picture step, `line_o` holds the line index, from 0 up to ACTIVE_LINES-1. Outside the picture step it is 0.
- R8: The first equalising pulse after the picture starts low on the cycle right after the last cycle of the last picture line, with no gap.
- R9: `frame_o` is high for exactly one cycle per frame. That cycle is the first cycle of the first broad pulse, so `sync_o` is low when it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_o | output | 1 | Sync level: 0 is the sync tip, 1 is the blanking level |
| active_o | output | 1 | Visible-video window strobe |
| line_o | output | LINE_W | Picture line index (LINE_W = clog2 of ACTIVE_LINES) |
| frame_o | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The checker watches the following on every cycle:
- the idle state under reset;
- that every low run of the sync output ends at one of the three legal tip widths, and never grows past the broad width;
- that the visible strobe only appears at blanking level with a line index in range;
- that the frame pulse is a single cycle coinciding with a sync tip.

Some properties only the bench can show, because they depend on position within the whole frame. These are:
- the order of the 17 steps;
- how many lines the picture holds;
- the exact cycle where each segment starts, including the gapless hand-over after the last line;
- that exactly one frame pulse occurs per frame.

The bench covers these over three frames, using a shortened picture.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  typedef enum logic [1:0] {
    SEG_BROAD   = 2'd0,
    SEG_EQUAL   = 2'd1,
    SEG_PICTURE = 2'd2
  } seg_kind_e;

  // Map a sequence step to the kind of segment it emits.
  function automatic seg_kind_e kind_of(input int step, input int broad_steps,
                                        input int picture_step);
    if (step < broad_steps)       return SEG_BROAD;
    else if (step == picture_step) return SEG_PICTURE;
    else                           return SEG_EQUAL;
  endfunction

endpackage

// File: rtl/cvs_cycle_timer.sv
module cvs_cycle_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_len,
  output logic [CNT_W-1:0] count,
  output logic             last
);

  assign last = (count == period_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (last) count <= '0;
    else           count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/cvs_status_seq.sv
module cvs_status_seq #(
  parameter int STEPS        = 17,
  parameter int PICTURE_STEP = 10,
  parameter int ACTIVE_LINES = 304,
  parameter int STAT_W       = 5,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_last,
  output logic [STAT_W-1:0] status,
  output logic [LINE_W-1:0] line,
  output logic              is_picture
);

  localparam logic [STAT_W-1:0] PIC_S  = STAT_W'(PICTURE_STEP);
  localparam logic [STAT_W-1:0] LAST_S = STAT_W'(STEPS - 1);
  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(ACTIVE_LINES - 1);

  assign is_picture = (status == PIC_S);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      line   <= '0;
    end else if (seg_last) begin
      if (is_picture) begin
        if (line == LAST_L) begin
          line   <= '0;
          status <= status + STAT_W'(1);
        end else begin
          line <= line + LINE_W'(1);
        end
      end else if (status >= LAST_S) begin
        status <= '0;
      end else begin
        status <= status + STAT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cvs_wave_out.sv
module cvs_wave_out
  import cvs_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int LINE_W    = 9,
  parameter int BROAD_LOW = 720,
  parameter int EQUAL_LOW = 48,
  parameter int HSYNC_LEN = 113,
  parameter int PORCH_LEN = 137
) (
  input  logic              clk,
  input  logic              rst,
  input  seg_kind_e         kind,
  input  logic [CNT_W-1:0]  count,
  input  logic [LINE_W-1:0] line,
  input  logic              first_step,
  output logic              sync_o,
  output logic              active_o,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_o
);

  localparam logic [CNT_W-1:0] C_BROAD = CNT_W'(BROAD_LOW);
  localparam logic [CNT_W-1:0] C_EQUAL = CNT_W'(EQUAL_LOW);
  localparam logic [CNT_W-1:0] C_HSYNC = CNT_W'(HSYNC_LEN);
  localparam logic [CNT_W-1:0] C_VIS   = CNT_W'(HSYNC_LEN + PORCH_LEN);

  logic tip_n;
  logic vis_n;

  always_comb begin
    vis_n = 1'b0;
    unique case (kind)
      SEG_BROAD:   tip_n = (count < C_BROAD);
      SEG_PICTURE: begin
        tip_n = (count < C_HSYNC);
        vis_n = (count >= C_VIS);
      end
      default:     tip_n = (count < C_EQUAL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o   <= 1'b1;
      active_o <= 1'b0;
      line_o   <= '0;
      frame_o  <= 1'b0;
    end else begin
      sync_o   <= ~tip_n;
      active_o <= vis_n;
      line_o   <= (kind == SEG_PICTURE) ? line : '0;
      frame_o  <= first_step && (count == '0);
    end
  end

endmodule

// File: rtl/cvs_sync_top.sv
module cvs_sync_top
  import cvs_pkg::*;
#(
  parameter int HALF_LINE    = 768,
  parameter int BROAD_LOW    = 720,
  parameter int EQUAL_LOW    = 48,
  parameter int LINE_LEN     = 1536,
  parameter int HSYNC_LEN    = 113,
  parameter int PORCH_LEN    = 137,
  parameter int ACTIVE_LINES = 304,
  parameter int STEPS        = 17,
  parameter int BROAD_STEPS  = 5,
  parameter int PICTURE_STEP = 10,
  localparam int LINE_W      = (ACTIVE_LINES > 1) ? $clog2(ACTIVE_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sync_o,
  output logic              active_o,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_o
);

  localparam int MAX_SEG = (LINE_LEN > HALF_LINE) ? LINE_LEN : HALF_LINE;
  localparam int CNT_W   = $clog2(MAX_SEG + 1);
  localparam int STAT_W  = $clog2(STEPS + 1);

  logic [CNT_W-1:0]  period_len;
  logic [CNT_W-1:0]  count;
  logic              seg_last;
  logic [STAT_W-1:0] status;
  logic [LINE_W-1:0] line;
  logic              is_picture;
  seg_kind_e         kind;

  assign period_len = is_picture ? CNT_W'(LINE_LEN) : CNT_W'(HALF_LINE);
  assign kind       = kind_of(int'(status), BROAD_STEPS, PICTURE_STEP);

  cvs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .period_len(period_len), .count(count), .last(seg_last)
  );

  cvs_status_seq #(
    .STEPS(STEPS), .PICTURE_STEP(PICTURE_STEP), .ACTIVE_LINES(ACTIVE_LINES),
    .STAT_W(STAT_W), .LINE_W(LINE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .seg_last(seg_last),
    .status(status), .line(line), .is_picture(is_picture)
  );

  cvs_wave_out #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .BROAD_LOW(BROAD_LOW), .EQUAL_LOW(EQUAL_LOW),
    .HSYNC_LEN(HSYNC_LEN), .PORCH_LEN(PORCH_LEN)
  ) u_wave (
    .clk(clk), .rst(rst), .kind(kind), .count(count), .line(line),
    .first_step(status == '0),
    .sync_o(sync_o), .active_o(active_o), .line_o(line_o), .frame_o(frame_o)
  );

endmodule

// File: rtl/cvs_sync_chk.sv
module cvs_sync_chk #(
  parameter int BROAD_LOW    = 720,
  parameter int EQUAL_LOW    = 48,
  parameter int HSYNC_LEN    = 113,
  parameter int ACTIVE_LINES = 304,
  parameter int LINE_W       = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_o,
  input logic              active_o,
  input logic [LINE_W-1:0] line_o,
  input logic              frame_o
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)          low_run <= '0;
    else if (!sync_o) low_run <= low_run + 16'd1;
    else              low_run <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (sync_o && !active_o && !frame_o && line_o == '0));

  // R9
  frame_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o);

  // R9
  frame_tip_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> !sync_o);

  // R6
  active_blank_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> sync_o);

  // R7
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (int'(line_o) < ACTIVE_LINES));

  // R3 R4 R6
  low_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> (int'(low_run) == BROAD_LOW || int'(low_run) == EQUAL_LOW ||
                       int'(low_run) == HSYNC_LEN));

  // R3
  low_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_o |-> (int'(low_run) < BROAD_LOW));

endmodule

bind cvs_sync_top cvs_sync_chk #(
  .BROAD_LOW(BROAD_LOW), .EQUAL_LOW(EQUAL_LOW), .HSYNC_LEN(HSYNC_LEN),
  .ACTIVE_LINES(ACTIVE_LINES), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst(rst), .sync_o(sync_o), .active_o(active_o),
  .line_o(line_o), .frame_o(frame_o)
);

// File: tb/test_cvs_sync_top.sv
module test_cvs_sync_top;

  localparam int LINES    = 8;
  localparam int HALF     = 768;
  localparam int LINE     = 1536;
  localparam int BROAD_LO = 720;
  localparam int EQ_LO    = 48;
  localparam int HS       = 113;
  localparam int BP       = 137;
  localparam int PRE      = 10 * HALF;
  localparam int FRAME    = 16 * HALF + LINES * LINE;
  localparam int NFR      = 3;
  localparam int LW       = $clog2(LINES);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sync_o, active_o, frame_o;
  logic [LW-1:0] line_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cvs_sync_top #(.ACTIVE_LINES(LINES)) i_cvs_sync_top (
    .clk(clk), .rst(rst), .sync_o(sync_o), .active_o(active_o),
    .line_o(line_o), .frame_o(frame_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: expected outputs at a given position in the stream.
  task automatic model(input int p, output bit s, output bit a, output bit f,
                       output int ln, output string tag);
    int q, c, r;
    q = p % FRAME;
    s = 1; a = 0; f = 0; ln = 0;
    if (q < PRE) begin
      c = q % HALF;
      if (q / HALF < 5) begin s = !(c < BROAD_LO); tag = "R3"; end
      else              begin s = !(c < EQ_LO);    tag = "R4"; end
      f = (q == 0);
      if (q == 0) tag = "R9";
    end else if (q < PRE + LINES * LINE) begin
      r = q - PRE;
      ln = r / LINE;
      c = r % LINE;
      s = !(c < HS);
      a = (c >= HS + BP);
      tag = (c == 0) ? "R5" : (c < HS + BP) ? "R6" : "R7";
    end else begin
      r = q - PRE - LINES * LINE;
      c = r % HALF;
      s = !(c < EQ_LO);
      tag = (r == 0) ? "R8" : "R4";
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int runs[$];
    int exp_runs[$];
    int run, frames, vis_lines, vis_per[NFR];
    bit prev_s, prev_a;

    // R1: idle state under reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 sync", int'(sync_o), 1);
      check("R1 active", int'(active_o), 0);
      check("R1 frame", int'(frame_o), 0);
    end
    rst = 1'b0;

    run = 0; frames = 0; prev_s = 1; prev_a = 0;
    for (int k = 0; k < NFR; k++) vis_per[k] = 0;

    for (int p = 0; p < NFR * FRAME; p++) begin
      bit es, ea, ef;
      int el;
      string tg;
      @(negedge clk);
      model(p, es, ea, ef, el, tg);
      compared++;
      if (sync_o !== es || active_o !== ea || frame_o !== ef || int'(line_o) != el) begin
        mismatched++;
        $display("FAIL %s pos=%0d actual s=%0b a=%0b f=%0b l=%0d expected s=%0b a=%0b f=%0b l=%0d",
                 tg, p, sync_o, active_o, frame_o, line_o, es, ea, ef, el);
      end
      if (!sync_o) run++;
      else if (!prev_s) begin runs.push_back(run); run = 0; end
      if (frame_o) frames++;
      if (active_o && !prev_a) vis_per[p / FRAME]++;
      prev_s = sync_o;
      prev_a = active_o;
    end

    // R2: ordered tip widths per frame (R3 broad, R4 equalising, R6 line sync)
    for (int k = 0; k < NFR; k++) begin
      for (int i = 0; i < 5; i++)     exp_runs.push_back(BROAD_LO);
      for (int i = 0; i < 5; i++)     exp_runs.push_back(EQ_LO);
      for (int i = 0; i < LINES; i++) exp_runs.push_back(HS);
      for (int i = 0; i < 6; i++)     exp_runs.push_back(EQ_LO);
    end
    check("R2 tip count", runs.size(), exp_runs.size());
    for (int i = 0; i < exp_runs.size() && i < runs.size(); i++)
      check("R2 tip width order", runs[i], exp_runs[i]);

    // R5: visible lines per frame
    for (int k = 0; k < NFR; k++) begin
      vis_lines = vis_per[k];
      check("R5 lines per frame", vis_lines, LINES);
    end
    // R9: one frame pulse per frame
    check("R9 frame pulses", frames, NFR);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule